// File: doc/BRIEF.md
# Handshaked Round-Robin Request Arbiter

This block chooses one requester out of an N-bit request vector and presents the choice as a one-hot grant vector with a valid/ready handshake. Priority runs from the most significant bit downwards. Once the consumer accepts a grant, the next grants go to set requests of lower index until none are left there. The search then wraps back to the top of the vector, so no steadily asserted request waits longer than one full rotation.

The grant is formed combinationally from the live request vector and a registered "eligible below" mask, with no output register. A change on the requests therefore reaches the grant output within the same cycle. The mask moves forward only on a cycle where valid and ready are both high. The reset input's active level is a parameter. Reset is asserted asynchronously and released through a two-stage synchroniser, so the state advances no earlier than the third rising edge after release.

Top module: `rr_grant_arbiter`

## Requirements
- R1: With the mask cleared, the grant is the highest-index set request bit.
- R2: `grant_vld_o` is high exactly when `grant_o` has a bit set.
- R3: `grant_o` is one-hot or zero, and never sets a bit whose request bit is clear.
- R4: After a grant of bit k is accepted (valid and ready both high at a rising edge), the next grant is the highest set request of index below k, if one exists.
- R5: If no request is set below the last accepted index, the grant wraps to the highest set request of the whole vector.
- R6: While `grant_rdy_i` is low, the arbitration state is held, so an unchanged request vector keeps the same grant.
- R7: A request change is visible on `grant_o` in the same cycle, with no register in the path.
- R8: With all requests zero, the grant is zero, valid is low, and a ready pulse leaves the state unchanged. This is observed through the grant that the next non-zero request pattern receives.
- R9: Reset clears the state asynchronously, so the first grant during or after reset is the highest set request.
- R10: `rst_in` is active at the level set by `RST_LEVEL`. The default is active low (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_in | input | 1 | Reset; its active level is set by RST_LEVEL |
| req_i | input | WIDTH | Request vector; a higher index has higher priority |
| grant_o | output | WIDTH | One-hot grant, combinational |
| grant_vld_o | output | 1 | High when any grant bit is set |
| grant_rdy_i | input | 1 | Consumer accepts the current grant |

## Verification
The grant and valid outputs are due in the same cycle as the request change, so the bench drives on the falling edge and samples one nanosecond later. The effect of an accepted handshake is due one rising edge later. The behavioural model, which tracks the last accepted index as an integer, is updated at that edge. It is compared again only after the next falling-edge drive. The three cycles after reset release are driven so that no handshake can occur while the synchroniser is still holding the state in reset.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  typedef enum logic {
    RST_LOW  = 1'b0,
    RST_HIGH = 1'b1
  } rst_level_e;
endpackage

// File: rtl/rr_rst_sync.sv
module rr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic srst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign srst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rr_top_pick.sv
// Keeps only the highest set bit of vec_i.
module rr_top_pick #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [WIDTH-1:0] pick_o,
  output logic             any_o
);
  logic [WIDTH:0] seen;   // seen[i]: some bit at index >= i is set

  assign seen[WIDTH] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign seen[i]   = seen[i+1] | vec_i[i];
    assign pick_o[i] = vec_i[i] & ~seen[i+1];
  end

  assign any_o = seen[0];
endmodule

// File: rtl/rr_mask_below.sv
// For a one-hot input, sets every bit strictly below the hot bit.
module rr_mask_below #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] onehot_i,
  output logic [WIDTH-1:0] below_o
);
  logic [WIDTH:0] above;

  assign above[WIDTH] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign above[i]   = above[i+1] | onehot_i[i];
    assign below_o[i] = above[i+1];
  end
endmodule

// File: rtl/rr_grant_arbiter.sv
module rr_grant_arbiter
  import rr_arb_pkg::*;
#(
  parameter int         WIDTH     = 8,
  parameter rst_level_e RST_LEVEL = RST_LOW
) (
  input  logic             clk_i,
  input  logic             rst_in,
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] grant_o,
  output logic             grant_vld_o,
  input  logic             grant_rdy_i
);
  localparam int SYNC_STAGES = 2;

  logic             arst_n;
  logic             srst_n;
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] mask_d;
  logic [WIDTH-1:0] req_masked;
  logic [WIDTH-1:0] pick_masked;
  logic [WIDTH-1:0] pick_full;
  logic             any_masked;
  logic             any_full;
  logic             adv_en;

  assign arst_n = (RST_LEVEL == RST_HIGH) ? ~rst_in : rst_in;

  rr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (arst_n),
    .srst_n_o (srst_n)
  );

  assign req_masked = req_i & mask_q;

  rr_top_pick #(.WIDTH(WIDTH)) u_pick_masked (
    .vec_i  (req_masked),
    .pick_o (pick_masked),
    .any_o  (any_masked)
  );

  rr_top_pick #(.WIDTH(WIDTH)) u_pick_full (
    .vec_i  (req_i),
    .pick_o (pick_full),
    .any_o  (any_full)
  );

  always_comb begin
    grant_o     = any_masked ? pick_masked : pick_full;
    grant_vld_o = any_full;
  end

  rr_mask_below #(.WIDTH(WIDTH)) u_mask_below (
    .onehot_i (grant_o),
    .below_o  (mask_d)
  );

  assign adv_en = grant_vld_o & grant_rdy_i;

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n)     mask_q <= '0;
    else if (adv_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/rr_arb_chk.sv
module rr_arb_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             srst_n,
  input logic [WIDTH-1:0] req_i,
  input logic [WIDTH-1:0] grant_o,
  input logic             grant_vld_o,
  input logic             grant_rdy_i,
  input logic [WIDTH-1:0] mask_q
);
  // R3
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    $onehot0(grant_o));

  // R3
  grant_subset_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    (grant_o & ~req_i) == '0);

  // R2
  vld_match_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    grant_vld_o == (grant_o != '0));

  // R1
  busy_vld_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    (req_i != '0) |-> grant_vld_o);

  // R6
  hold_state_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    !(grant_vld_o && grant_rdy_i) |=> $stable(mask_q));

  // R4
  granted_excl_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    (grant_vld_o && grant_rdy_i) |=> ((mask_q & $past(grant_o)) == '0));
endmodule

bind rr_grant_arbiter rr_arb_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .srst_n      (srst_n),
  .req_i       (req_i),
  .grant_o     (grant_o),
  .grant_vld_o (grant_vld_o),
  .grant_rdy_i (grant_rdy_i),
  .mask_q      (mask_q)
);

// File: tb/tb_rr_grant_arbiter.sv
module tb_rr_grant_arbiter;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_in;
  logic [W-1:0] req_i;
  logic [W-1:0] grant_o;
  logic         grant_vld_o;
  logic         grant_rdy_i;

  int n_checks = 0;
  int n_fail   = 0;
  int last_idx = W;   // W means no accepted grant yet
  bit done     = 1'b0;

  rr_grant_arbiter #(.WIDTH(W)) dut (
    .clk_i       (clk_i),
    .rst_in      (rst_in),
    .req_i       (req_i),
    .grant_o     (grant_o),
    .grant_vld_o (grant_vld_o),
    .grant_rdy_i (grant_rdy_i)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [W-1:0] model_grant(input logic [W-1:0] r, input int last);
    logic [W-1:0] g = '0;
    for (int i = W - 1; i >= 0; i--)
      if (g == '0 && r[i] && i < last) g[i] = 1'b1;
    if (g == '0)
      for (int i = W - 1; i >= 0; i--)
        if (g == '0 && r[i]) g[i] = 1'b1;
    return g;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, sample 1 ns later, then let the model follow the rising edge.
  task automatic step(input string tag, input logic [W-1:0] r, input logic rdy, input logic rst_act);
    logic [W-1:0] exp;
    @(negedge clk_i);
    req_i       = r;
    grant_rdy_i = rdy;
    rst_in      = rst_act ? 1'b0 : 1'b1;
    if (rst_act) last_idx = W;
    #1;
    exp = model_grant(r, last_idx);
    check(tag, grant_o, exp);
    check({tag, " R2 valid"}, {{(W-1){1'b0}}, grant_vld_o}, {{(W-1){1'b0}}, exp != '0});
    check({tag, " R3 onehot/subset"},
          {{(W-1){1'b0}}, ($countones(grant_o) <= 1) && ((grant_o & ~r) == '0)},
          {{(W-1){1'b0}}, 1'b1});
    @(posedge clk_i);
    if (!rst_act && rdy && exp != '0)
      for (int i = 0; i < W; i++) if (exp[i]) last_idx = i;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr = 16'hACE1;
    req_i = '0; grant_rdy_i = 1'b0; rst_in = 1'b0;
    // R9 R10: active-low reset held, grant goes to the highest request
    step("R9 R10 reset", 8'hA5, 1'b1, 1'b1);
    step("R9 R10 reset", 8'hA5, 1'b1, 1'b1);
    // R8: idle with ready high while the synchroniser releases
    for (int k = 0; k < 3; k++) step("R8 idle", 8'h00, 1'b1, 1'b0);
    // R1 R4 R5: rotation 7,5,2,0 then wrap to 7
    step("R1 first", 8'hA5, 1'b1, 1'b0);
    step("R4 next", 8'hA5, 1'b1, 1'b0);
    step("R4 next", 8'hA5, 1'b1, 1'b0);
    step("R4 next", 8'hA5, 1'b1, 1'b0);
    step("R5 wrap", 8'hA5, 1'b1, 1'b0);
    // R6: no ready, grant held at bit 5
    step("R6 hold", 8'hA5, 1'b0, 1'b0);
    step("R6 hold", 8'hA5, 1'b0, 1'b0);
    // R7: request change shows in the same cycle
    step("R7 comb", 8'h45, 1'b0, 1'b0);
    step("R7 comb", 8'h05, 1'b0, 1'b0);
    // R8: zero requests with ready, state kept (last index 7 -> bit 0 next)
    step("R8 zero", 8'h00, 1'b1, 1'b0);
    step("R8 zero", 8'h00, 1'b1, 1'b0);
    step("R8 kept", 8'h81, 1'b1, 1'b0);
    step("R5 wrap", 8'h81, 1'b1, 1'b0);
    // R1 R4 R5: pseudo-random traffic
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R4 random", lfsr[7:0] & lfsr[15:8], lfsr[3] | lfsr[9], 1'b0);
    end
    // R9: reset asserted mid-run clears state at once
    step("R4 pre", 8'hFF, 1'b1, 1'b0);
    step("R9 mid reset", 8'hFF, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) step("R6 settle", 8'h18, 1'b0, 1'b0);
    step("R1 after reset", 8'h18, 1'b1, 1'b0);
    step("R4 after reset", 8'h18, 1'b1, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule